// File: doc/BRIEF.md
# Almost-empty / almost-full offset programmer

This unit holds the four threshold offsets that two FIFOs use to raise their almost-empty and almost-full flags: an almost-full and an almost-empty offset for the first FIFO (`ofs_y1`, `ofs_x1`) and the same pair for the second FIFO (`ofs_y2`, `ofs_x2`). Each offset is `AW` bits wide, where `AW` is the FIFO address width. The FIFO datapath and the flag comparators are outside this block.

While master reset is held low, a three-bit select and a parity-layout select are captured. The value seen on the last clock edge before master reset is released fixes the programming method until the next master reset. There are three methods. A preset method loads one of five constant offsets into all four registers. A parallel method takes one register per write strobe from a 36-bit data word. A serial method shifts in one bit per clock edge while the serial enable is low, MSB first, through one chain made of all four registers.

The `done` output tells the FIFOs that the thresholds are valid. Partial reset flushes the FIFOs elsewhere; here it only freezes programming and keeps every value.

Top module: `fofs_prog`

## Requirements
- R1: The method is fixed by `sel` and `ipar_sel` on the last clock edge with `mrst_n` low. Changes on `sel` or `ipar_sel` after release do not alter the offsets or `done`.
- R2: The preset codes of `sel` are 3'b010=8, 3'b011=16, 3'b100=64, 3'b101=256 and 3'b110=1024. The code is loaded into all four offsets during master reset, and `done` is 1 from the first reset edge onward.
- R3: In serial mode (`sel`=3'b000), each clock edge with `ser_en_n`=0 shifts `ser_d` into the LSB of `ofs_x2`. Each register's MSB passes on to the LSB of the next register up the chain (x2→y2→x1→y1). An edge with `ser_en_n`=1 shifts nothing.
- R4: A serial load takes exactly 4*AW bits. The first bit becomes the MSB of `ofs_y1` and the last bit becomes the LSB of `ofs_x2`, so the stream order is Y1, X1, Y2, X2. `done` rises on the edge that takes the final bit.
- R5: Once `done` is 1, further serial bits and parallel write strobes leave all offsets unchanged.
- R6: In parallel mode (`sel`=3'b001 or 3'b111), each edge with `ld_we`=1 writes the next register in the order Y1, X1, Y2, X2. `done` rises with the fourth write.
- R7: With `ipar_sel`=0 a parallel write stores `ld_data[AW-1:0]`. With `ipar_sel`=1 bit 8 is dropped, and the register takes the low AW bits of {`ld_data[35:9]`, `ld_data[7:0]`}.
- R8: While `prst_n`=0, serial bits and write strobes are ignored, and the offsets, the method and `done` are kept. Programming resumes where it stopped once `prst_n` returns to 1.
- R9: For serial and parallel modes, master reset clears all four offsets to 0 and `done` to 0, and restarts the load at Y1.
- R10: In serial mode `ld_we` has no effect, and in parallel mode `ser_en_n` and `ser_d` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously |
| prst_n | input | 1 | Partial reset, active low; freezes programming |
| sel | input | 3 | Programming method / preset code, captured during master reset |
| ipar_sel | input | 1 | 1 = interspersed parity layout (bit 8 skipped), captured during master reset |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_d | input | 1 | Serial offset bit |
| ld_we | input | 1 | Parallel write strobe |
| ld_data | input | DW (36) | Parallel offset data word |
| ofs_y1 | output | AW | Almost-full offset, first FIFO |
| ofs_x1 | output | AW | Almost-empty offset, first FIFO |
| ofs_y2 | output | AW | Almost-full offset, second FIFO |
| ofs_x2 | output | AW | Almost-empty offset, second FIFO |
| done | output | 1 | All four offsets are programmed |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `mrst_n` stays low across at least one rising edge, so the method and the offsets start from defined values. The properties are disabled during master reset, and they only relate the state of one edge to the next after release. The bench changes every input on the falling clock edge and holds master reset low for two edges. It changes `sel` and `ipar_sel` only around reset, except in the deliberate R1 test that moves them after release.

// File: rtl/fofs_pkg.sv
package fofs_pkg;

   typedef enum logic [1:0] {
      FM_SERIAL   = 2'd0,
      FM_PARALLEL = 2'd1,
      FM_PRESET   = 2'd2
   } fofs_mode_e;

   // method chosen by the three select lines
   function automatic fofs_mode_e sel_mode(input logic [2:0] s);
      case (s)
         3'b000:          return FM_SERIAL;
         3'b001, 3'b111:  return FM_PARALLEL;
         default:         return FM_PRESET;
      endcase
   endfunction

   // preset offset for a preset code (0 for non-preset codes)
   function automatic logic [31:0] preset_val(input logic [2:0] s);
      case (s)
         3'b010:  return 32'd8;
         3'b011:  return 32'd16;
         3'b100:  return 32'd64;
         3'b101:  return 32'd256;
         3'b110:  return 32'd1024;
         default: return 32'd0;
      endcase
   endfunction

endpackage

// File: rtl/fofs_mode_latch.sv
module fofs_mode_latch
   import fofs_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic [2:0]       sel,
   input  logic             ipar_sel,
   output fofs_mode_e       mode_q,
   output logic             ipar_q,
   output fofs_mode_e       rst_mode,
   output logic [AW-1:0]    rst_val
);

   assign rst_mode = sel_mode(sel);
   assign rst_val  = AW'(preset_val(sel));

   // the value held on the last reset edge is the one kept
   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q <= rst_mode;
         ipar_q <= ipar_sel;
      end
   end

endmodule

// File: rtl/fofs_par_pack.sv
module fofs_par_pack #(
   parameter int DW       = 36,
   parameter int AW       = 11,
   parameter int SKIP_BIT = 8
) (
   input  logic [DW-1:0]  data,
   input  logic           ipar,
   output logic [AW-1:0]  val
);

   generate
      if (AW > SKIP_BIT) begin : g_skip
         logic [AW-1:0] squeezed;
         assign squeezed = {data[AW:SKIP_BIT+1], data[SKIP_BIT-1:0]};
         assign val      = ipar ? squeezed : data[AW-1:0];
      end else begin : g_noskip
         logic unused_ipar;
         assign unused_ipar = ipar ^ data[AW];
         assign val = data[AW-1:0];
      end

      if (DW > AW + 1) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^data[DW-1:AW+1];
      end
   endgenerate

endmodule

// File: rtl/fofs_load_ctrl.sv
module fofs_load_ctrl
   import fofs_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  fofs_mode_e        mode_q,
   input  fofs_mode_e        rst_mode,
   input  logic [AW-1:0]     rst_val,
   input  logic              ser_en_n,
   input  logic              ser_d,
   input  logic              ld_we,
   input  logic [AW-1:0]     pval,
   output logic [4*AW-1:0]   chain,
   output logic              done
);

   localparam int NREG = 4;
   localparam int NB   = NREG * AW;
   localparam int CW   = $clog2(NB + 1);
   localparam logic [CW-1:0] LAST_SER = CW'(NB - 1);
   localparam logic [CW-1:0] LAST_PAR = CW'(NREG - 1);

   logic [CW-1:0] cnt;
   logic          active;

   assign active = prst_n && !done;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         chain <= (rst_mode == FM_PRESET) ? {NREG{rst_val}} : '0;
         done  <= (rst_mode == FM_PRESET);
         cnt   <= '0;
      end else if (active) begin
         case (mode_q)
            FM_SERIAL: begin
               if (!ser_en_n) begin
                  chain <= {chain[NB-2:0], ser_d};
                  cnt   <= cnt + 1'b1;
                  if (cnt == LAST_SER) done <= 1'b1;
               end
            end
            FM_PARALLEL: begin
               if (ld_we) begin
                  for (int k = 0; k < NREG; k++) begin
                     if (cnt == CW'(k)) chain[(NREG-1-k)*AW +: AW] <= pval;
                  end
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_PAR) done <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   a_r4_done_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
      done |=> done);

   a_r5_frozen_after_done: assert property (@(posedge clk) disable iff (!mrst_n)
      done |=> $stable(chain));

   a_r8_partial_hold: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> ($stable(chain) && $stable(done) && $stable(cnt)));

   a_r3_idle_no_shift: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == FM_SERIAL && ser_en_n) |=> $stable(chain));

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!mrst_n)
      cnt <= CW'(NB));

   a_r6_par_step: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == FM_PARALLEL && ld_we && active) |=> (cnt == $past(cnt) + 1'b1));

   a_r10_par_ignores_serial: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == FM_PARALLEL && !ld_we) |=> $stable(chain));

endmodule

// File: rtl/fofs_prog.sv
module fofs_prog
   import fofs_pkg::*;
#(
   parameter int AW = 11,
   parameter int DW = 36
) (
   input  logic           clk,
   input  logic           mrst_n,
   input  logic           prst_n,
   input  logic [2:0]     sel,
   input  logic           ipar_sel,
   input  logic           ser_en_n,
   input  logic           ser_d,
   input  logic           ld_we,
   input  logic [DW-1:0]  ld_data,
   output logic [AW-1:0]  ofs_y1,
   output logic [AW-1:0]  ofs_x1,
   output logic [AW-1:0]  ofs_y2,
   output logic [AW-1:0]  ofs_x2,
   output logic           done
);

   generate
      if (AW < 11) begin : g_chk_aw
         $error("fofs_prog: AW must hold the largest preset (1024)");
      end
      if (DW < AW + 1) begin : g_chk_dw
         $error("fofs_prog: DW must exceed AW");
      end
   endgenerate

   fofs_mode_e        mode_q;
   fofs_mode_e        rst_mode;
   logic              ipar_q;
   logic [AW-1:0]     rst_val;
   logic [AW-1:0]     pval;
   logic [4*AW-1:0]   chain;

   fofs_mode_latch #(.AW(AW)) u_mode (
      .clk      (clk),
      .mrst_n   (mrst_n),
      .sel      (sel),
      .ipar_sel (ipar_sel),
      .mode_q   (mode_q),
      .ipar_q   (ipar_q),
      .rst_mode (rst_mode),
      .rst_val  (rst_val)
   );

   fofs_par_pack #(.DW(DW), .AW(AW), .SKIP_BIT(8)) u_pack (
      .data (ld_data),
      .ipar (ipar_q),
      .val  (pval)
   );

   fofs_load_ctrl #(.AW(AW)) u_load (
      .clk      (clk),
      .mrst_n   (mrst_n),
      .prst_n   (prst_n),
      .mode_q   (mode_q),
      .rst_mode (rst_mode),
      .rst_val  (rst_val),
      .ser_en_n (ser_en_n),
      .ser_d    (ser_d),
      .ld_we    (ld_we),
      .pval     (pval),
      .chain    (chain),
      .done     (done)
   );

   assign ofs_y1 = chain[4*AW-1:3*AW];
   assign ofs_x1 = chain[3*AW-1:2*AW];
   assign ofs_y2 = chain[2*AW-1:AW];
   assign ofs_x2 = chain[AW-1:0];

   a_r2_preset_done: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == FM_PRESET) |-> done);

   a_r1_mode_kept: assert property (@(posedge clk) disable iff (!mrst_n)
      1'b1 |=> $stable(mode_q));

endmodule

// File: tb/fofs_prog_tb.sv
module fofs_prog_tb_top;

   localparam int AW = 11;
   localparam int DW = 36;
   localparam int NB = 4 * AW;

   logic           clk = 1'b0;
   logic           mrst_n = 1'b0;
   logic           prst_n = 1'b1;
   logic [2:0]     sel = 3'b000;
   logic           ipar_sel = 1'b0;
   logic           ser_en_n = 1'b1;
   logic           ser_d = 1'b0;
   logic           ld_we = 1'b0;
   logic [DW-1:0]  ld_data = '0;
   logic [AW-1:0]  ofs_y1, ofs_x1, ofs_y2, ofs_x2;
   logic           done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   fofs_prog #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .sel(sel),
      .ipar_sel(ipar_sel), .ser_en_n(ser_en_n), .ser_d(ser_d),
      .ld_we(ld_we), .ld_data(ld_data), .ofs_y1(ofs_y1), .ofs_x1(ofs_x1),
      .ofs_y2(ofs_y2), .ofs_x2(ofs_x2), .done(done)
   );

   // preset table: {code, expected offset}
   localparam logic [13:0] PRESET_TAB [5] = '{
      {3'b010, 11'd8}, {3'b011, 11'd16}, {3'b100, 11'd64},
      {3'b101, 11'd256}, {3'b110, 11'd1024}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [AW-1:0] y1, input logic [AW-1:0] x1,
                          input logic [AW-1:0] y2, input logic [AW-1:0] x2, input logic d);
      chk({tag, " y1"}, 64'(ofs_y1), 64'(y1));
      chk({tag, " x1"}, 64'(ofs_x1), 64'(x1));
      chk({tag, " y2"}, 64'(ofs_y2), 64'(y2));
      chk({tag, " x2"}, 64'(ofs_x2), 64'(x2));
      chk({tag, " done"}, 64'(done), 64'(d));
   endtask

   task automatic do_reset(input logic [2:0] s, input logic ip);
      @(negedge clk);
      mrst_n = 1'b0; sel = s; ipar_sel = ip;
      repeat (2) @(negedge clk);
      mrst_n = 1'b1;
   endtask

   task automatic ser_bit(input logic b);
      @(negedge clk);
      ser_d = b; ser_en_n = 1'b0;
      @(negedge clk);
      ser_en_n = 1'b1;
   endtask

   task automatic par_wr(input logic [DW-1:0] d);
      @(negedge clk);
      ld_data = d; ld_we = 1'b1;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   function automatic logic [AW-1:0] squeeze(input logic [DW-1:0] d);
      logic [DW-2:0] t;
      t = {d[DW-1:9], d[7:0]};
      return t[AW-1:0];
   endfunction

   initial begin
      logic [AW-1:0] vy1, vx1, vy2, vx2;
      logic [NB-1:0] stream;
      logic [DW-1:0] w0, w1, w2, w3;

      // presets, walked from the table (R2), with later select changes (R1)
      for (int i = 0; i < 5; i++) begin
         do_reset(PRESET_TAB[i][13:11], 1'b0);
         chk_all("R2 preset", PRESET_TAB[i][10:0], PRESET_TAB[i][10:0],
                 PRESET_TAB[i][10:0], PRESET_TAB[i][10:0], 1'b1);
         sel = ~PRESET_TAB[i][13:11];
         ipar_sel = 1'b1;
         par_wr(36'hF_FFFF_FFFF);
         ser_bit(1'b1);
         chk_all("R1 sel after release", PRESET_TAB[i][10:0], PRESET_TAB[i][10:0],
                 PRESET_TAB[i][10:0], PRESET_TAB[i][10:0], 1'b1);
      end

      // partial reset keeps preset values (R8)
      @(negedge clk); prst_n = 1'b0;
      @(negedge clk); prst_n = 1'b1;
      chk_all("R8 prst on preset", 11'd1024, 11'd1024, 11'd1024, 11'd1024, 1'b1);

      // serial mode
      vy1 = 11'h5A3; vx1 = 11'h0F1; vy2 = 11'h7FE; vx2 = 11'h001;
      stream = {vy1, vx1, vy2, vx2};
      do_reset(3'b000, 1'b0);
      sel = 3'b001;
      chk_all("R9 serial reset", '0, '0, '0, '0, 1'b0);
      for (int i = NB - 1; i >= NB - AW; i--) ser_bit(stream[i]);
      chk_all("R3 first word in x2", '0, '0, '0, vy1, 1'b0);
      // idle edges with data toggling
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); ser_d = ~ser_d;
      end
      chk("R3 enable high no shift", 64'(ofs_x2), 64'(vy1));
      par_wr(36'h0_0000_07FF);
      chk_all("R10 strobe ignored in serial", '0, '0, '0, vy1, 1'b0);
      for (int i = NB - AW - 1; i >= 1; i--) ser_bit(stream[i]);
      chk("R4 done low before last bit", 64'(done), 64'd0);
      ser_bit(stream[0]);
      chk_all("R4 serial complete", vy1, vx1, vy2, vx2, 1'b1);
      for (int i = 0; i < 5; i++) ser_bit(1'b1);
      chk_all("R5 serial after done", vy1, vx1, vy2, vx2, 1'b1);

      // parallel mode, plain layout
      w0 = 36'hABCDE_1234; w1 = 36'h1_0000_0B5A; w2 = 36'h7_FFFF_F800; w3 = 36'h0_0000_0155;
      do_reset(3'b001, 1'b0);
      chk_all("R9 parallel reset", '0, '0, '0, '0, 1'b0);
      ser_bit(1'b1);
      chk_all("R10 serial ignored in parallel", '0, '0, '0, '0, 1'b0);
      par_wr(w0);
      par_wr(w1);
      chk_all("R6 two writes", w0[AW-1:0], w1[AW-1:0], '0, '0, 1'b0);
      // partial reset mid-load with strobe held (R8)
      @(negedge clk); prst_n = 1'b0; ld_we = 1'b1; ld_data = 36'h0_0000_0333;
      @(negedge clk); ld_we = 1'b0; prst_n = 1'b1;
      chk_all("R8 strobe ignored in prst", w0[AW-1:0], w1[AW-1:0], '0, '0, 1'b0);
      par_wr(w2);
      chk("R6 done low after three", 64'(done), 64'd0);
      par_wr(w3);
      chk_all("R6 parallel complete", w0[AW-1:0], w1[AW-1:0], w2[AW-1:0], w3[AW-1:0], 1'b1);
      par_wr(36'h0_0000_0444);
      chk_all("R5 write after done", w0[AW-1:0], w1[AW-1:0], w2[AW-1:0], w3[AW-1:0], 1'b1);

      // parallel mode, interspersed parity layout, alternate code (R7)
      do_reset(3'b111, 1'b1);
      ipar_sel = 1'b0;
      par_wr(w1);
      par_wr(w0);
      par_wr(w2);
      par_wr(w3);
      chk_all("R7 parity skip", squeeze(w1), squeeze(w0), squeeze(w2), squeeze(w3), 1'b1);
      chk("R7 bit8 case", 64'(ofs_y1), 64'h55A);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule